// File: doc/BRIEF.md
# Third-Order Fractional-N Divide Sequence Generator

This block produces the instantaneous feedback divide ratio for a fractional-N frequency synthesizer. Each time the reference tick enable is high, it adds a 12-bit integer word to a small signed correction. That correction comes from a third-order noise-shaping modulator, which is driven by a 25-bit fractional word. Over many ticks, the mean of the ratios it emits converges to `INT + FRAC / 2^25`. The synthesized frequency is therefore the phase-detector rate times that mean. For example, a ratio of 61.5 is obtained with an integer word of 61 and a fractional word of 2^24.

The modulator is a cascade of three first-order 25-bit accumulators. The input of each stage is the new running sum of the stage before it. The three carry bits pass through a difference network that cancels the quantisation error of the first two stages. This leaves a correction between -3 and +4. The integer and fractional words are copied into working registers only on an explicit load strobe. A load never clears the accumulators, so retuning does not restart the noise-shaping state. The registered ratio and a one-cycle valid pulse follow each tick by one clock.

Top module: `fracn_seq_gen`

## Requirements
- R1: On a synchronous reset (rst_n low at a clock edge), div_ratio becomes 0 and div_valid becomes 0. The working integer word becomes 31 and the working fractional word becomes 0, so the first tick after reset yields a ratio of 31.
- R2: The working words change only at a clock edge where load is 1. At other edges, changes on int_word or frac_word have no effect on any later output until a load.
- R3: A loaded integer word below 31 is captured as 31. Any value from 31 to 4095 is captured unchanged.
- R4: When the fractional word is 0 and the accumulators are still at their reset value, every tick yields exactly the integer word.
- R5: Every ratio that is flagged valid lies between INT-3 and INT+4, where INT is the working integer word used at that tick. The output is 13 bits wide, so it can hold 4099.
- R6: div_valid is 1 exactly in the cycle after an edge where tick_en was 1. div_ratio holds its value after an edge where tick_en was 0.
- R7: At a tick, each stage k adds its input to its own 25-bit accumulator, modulo 2^25, and produces carry ck when the sum reaches 2^25. Stage 1 adds the working fractional word. Stages 2 and 3 add the new sum of the previous stage. The ratio is INT + c1 + (c2 - c2') + (c3 - 2·c3' + c3''). Here c2' and c3' are the carries of the previous tick, and c3'' is the carry of the tick before that.
- R8: Over 65536 consecutive ticks with fixed words, the sum of the ratios differs from 65536·(INT + FRAC/2^25) by no more than 8.
- R9: When load and tick_en are both 1 at the same edge, that tick uses the previously loaded words. The new words apply from the next tick onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Reference tick: advances the modulator one step |
| load | input | 1 | Captures int_word and frac_word into the working registers |
| int_word | input | 12 | Integer part of the divide ratio (31 to 4095) |
| frac_word | input | 25 | Fractional numerator over 2^25 |
| div_ratio | output | 13 | Instantaneous divide ratio from the latest tick |
| div_valid | output | 1 | One-cycle pulse marking a new div_ratio |

## Verification
- **Zero fraction from reset.** A run of ticks with a zero fraction from reset must reproduce the integer word exactly. This separates a correctly idle modulator from one that leaks carries.
- **Half-integer ratio.** The 61.5 setting has a fraction of exactly 2^24. It produces a short, regular carry pattern, and both its cycle-by-cycle sequence and its long-run mean are compared with a behavioural model.
- **Near-full-scale setting.** The largest integer with the largest fraction drives the output toward its upper range limit and carries almost every tick. This exposes truncated adders and output overflow.
- **Load and tick timing.** Ticks sparser than the clock, and a load issued in the same cycle as a tick, show whether words take effect and outputs update on the right edge.

// File: rtl/fracn_pkg.sv
// Package: fracn_pkg
// Shared constants and types for the fractional-N sequence generator.
// Assumes a fixed third-order cascade. The carry correction then spans
// -3..+4 and fits a 4-bit signed value.
package fracn_pkg;

    // Number of cascaded first-order accumulator stages
    localparam int MASH_ORDER = 3;

    // Width of the signed carry correction
    localparam int OFS_W = 4;

    // Lowest and highest correction the difference network can produce
    localparam int OFS_MIN = -3;
    localparam int OFS_MAX = 4;

    typedef logic signed [OFS_W-1:0] ofs_t;

    // Widen one carry bit to a signed correction term
    function automatic ofs_t bit_to_ofs(input logic b);
        return ofs_t'({{(OFS_W-1){1'b0}}, b});
    endfunction

endpackage

// File: rtl/fracn_word_latch.sv
// Module: fracn_word_latch
// Holds the working integer and fractional words.
// New values are captured only when load is high. An integer word below
// INT_MIN is raised to INT_MIN at capture.
// Assumes INT_MIN fits in INT_W bits.
module fracn_word_latch #(
    parameter int INT_W   = 12,
    parameter int FRAC_W  = 25,
    parameter int INT_MIN = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [INT_W-1:0]  int_word,
    input  logic [FRAC_W-1:0] frac_word,
    output logic [INT_W-1:0]  int_q,
    output logic [FRAC_W-1:0] frac_q
);

    localparam logic [INT_W-1:0] INT_FLOOR = INT_MIN[INT_W-1:0];

    logic [INT_W-1:0] int_clamped;

    // Raise an out-of-range integer word to the legal floor
    always_comb begin
        int_clamped = (int_word < INT_FLOOR) ? INT_FLOOR : int_word;
    end

    // Capture both words on the load strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_q  <= INT_FLOOR;
            frac_q <= '0;
        end else if (load) begin
            int_q  <= int_clamped;
            frac_q <= frac_word;
        end
    end

    // R2: working words do not move without a load
    a_r2_hold_without_load: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(load)) |-> ($stable(int_q) && $stable(frac_q)));

    // R3: a loaded integer is either the requested value or the floor
    a_r3_int_floor: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(load)) |->
            ((int_q >= INT_FLOOR) &&
             ((int_q == $past(int_word)) || ($past(int_word) < INT_FLOOR))));

endmodule

// File: rtl/fracn_accum_stage.sv
// Module: fracn_accum_stage
// One first-order accumulator of the cascade.
// sum_o and carry_o show the wrapped sum and overflow that the next step
// would store. The stored value advances only when step is high.
// Assumes the addend is already stable in the cycle of the step.
module fracn_accum_stage #(
    parameter int W = 25
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic [W-1:0] addend,
    output logic [W-1:0] sum_o,
    output logic         carry_o
);

    logic [W-1:0] acc;
    logic [W:0]   wide;

    // Add with one extra bit to expose the wrap-around carry
    always_comb begin
        wide    = {1'b0, acc} + {1'b0, addend};
        sum_o   = wide[W-1:0];
        carry_o = wide[W];
    end

    // Store the wrapped sum on each step. A load never clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (step) begin
            acc <= sum_o;
        end
    end

    // R6: the accumulator is frozen between ticks
    a_r6_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(step)) |-> $stable(acc));

endmodule

// File: rtl/fracn_carry_shaper.sv
// Module: fracn_carry_shaper
// Difference network of the third-order cascade.
// It combines this tick's carries with the history of earlier ticks into a
// signed correction: c1 + (c2 - c2') + (c3 - 2*c3' + c3'').
// The history registers advance only on step.
module fracn_carry_shaper
    import fracn_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  step,
    input  logic [MASH_ORDER-1:0] carry_i,
    output ofs_t                  offset_o
);

    logic c2_z1;
    logic c3_z1;
    logic c3_z2;

    // Combine current carries with their delayed copies
    always_comb begin
        offset_o = bit_to_ofs(carry_i[0])
                 + bit_to_ofs(carry_i[1]) - bit_to_ofs(c2_z1)
                 + bit_to_ofs(carry_i[2]) - (bit_to_ofs(c3_z1) <<< 1)
                 + bit_to_ofs(c3_z2);
    end

    // Shift the carry history once per tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c2_z1 <= 1'b0;
            c3_z1 <= 1'b0;
            c3_z2 <= 1'b0;
        end else if (step) begin
            c2_z1 <= carry_i[1];
            c3_z1 <= carry_i[2];
            c3_z2 <= c3_z1;
        end
    end

    // R5: the correction stays inside its documented span
    a_r5_offset_range: assert property (@(posedge clk) disable iff (!rst_n)
        (offset_o >= ofs_t'(OFS_MIN)) && (offset_o <= ofs_t'(OFS_MAX)));

    // R6: history does not shift between ticks
    a_r6_history_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(step)) |-> $stable({c2_z1, c3_z1, c3_z2}));

endmodule

// File: rtl/fracn_seq_gen.sv
// Module: fracn_seq_gen (top)
// Fractional-N divide sequence generator.
// A three-stage accumulator cascade is driven by the working fractional
// word. Its shaped carry correction is added to the working integer word
// on every tick, and the result is registered with a one-cycle valid pulse.
// Assumes integer words of INT_MIN or more, which gives a non-negative result.
module fracn_seq_gen
    import fracn_pkg::*;
#(
    parameter int INT_W   = 12,
    parameter int FRAC_W  = 25,
    parameter int INT_MIN = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              load,
    input  logic [INT_W-1:0]  int_word,
    input  logic [FRAC_W-1:0] frac_word,
    output logic [INT_W:0]    div_ratio,
    output logic              div_valid
);

    localparam int RATIO_W = INT_W + 1;

    logic [INT_W-1:0]      int_q;
    logic [FRAC_W-1:0]     frac_q;
    logic [FRAC_W-1:0]     stage_in  [MASH_ORDER];
    logic [FRAC_W-1:0]     stage_sum [MASH_ORDER];
    logic [MASH_ORDER-1:0] carries;
    logic                  unused_tail_sum;
    ofs_t                  offset;
    logic [RATIO_W-1:0]    ratio_next;

    fracn_word_latch #(
        .INT_W  (INT_W),
        .FRAC_W (FRAC_W),
        .INT_MIN(INT_MIN)
    ) words_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .int_word (int_word),
        .frac_word(frac_word),
        .int_q    (int_q),
        .frac_q   (frac_q)
    );

    // Build the cascade: stage 0 takes the fraction, later stages take the previous sum
    for (genvar g = 0; g < MASH_ORDER; g++) begin : g_stage
        if (g == 0) begin : g_head
            assign stage_in[g] = frac_q;
        end else begin : g_tail
            assign stage_in[g] = stage_sum[g-1];
        end

        fracn_accum_stage #(
            .W(FRAC_W)
        ) acc_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .step   (tick_en),
            .addend (stage_in[g]),
            .sum_o  (stage_sum[g]),
            .carry_o(carries[g])
        );
    end

    // The last stage's sum feeds nothing further
    assign unused_tail_sum = ^stage_sum[MASH_ORDER-1];

    fracn_carry_shaper shaper_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (tick_en),
        .carry_i (carries),
        .offset_o(offset)
    );

    // Add the sign-extended correction to the integer word
    always_comb begin
        ratio_next = {1'b0, int_q}
                   + {{(RATIO_W-OFS_W){offset[OFS_W-1]}}, offset};
    end

    // Register the ratio on a tick and flag it for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_ratio <= '0;
            div_valid <= 1'b0;
        end else begin
            div_valid <= tick_en;
            if (tick_en) begin
                div_ratio <= ratio_next;
            end
        end
    end

    // R5: each valid ratio sits within INT-3 .. INT+4 of the integer used at its tick
    a_r5_ratio_range: assert property (@(posedge clk) disable iff (!rst_n)
        div_valid |->
            (({1'b0, $past(int_q)} <= div_ratio + RATIO_W'(3)) &&
             (div_ratio <= {1'b0, $past(int_q)} + RATIO_W'(4))));

    // R6: valid follows the tick by exactly one cycle
    a_r6_valid_follows_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (div_valid == $past(tick_en)));

    // R6: the ratio holds after a cycle with no tick
    a_r6_ratio_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(tick_en)) |-> $stable(div_ratio));

endmodule

// File: tb/fracn_seq_gen_tb.sv
// Bench for fracn_seq_gen: behavioural reference model compared every clock,
// plus directed checks and long-run mean checks.
module fracn_seq_gen_tb_top;

    localparam longint MODV = 64'd1 << 25;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        load = 1'b0;
    logic [11:0] int_word = '0;
    logic [24:0] frac_word = '0;
    logic [12:0] div_ratio;
    logic        div_valid;

    int total = 0;
    int bad = 0;

    fracn_seq_gen dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .load     (load),
        .int_word (int_word),
        .frac_word(frac_word),
        .div_ratio(div_ratio),
        .div_valid(div_valid)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model, updated at each rising edge
    longint m_acc [3];
    int     m_int = 31;
    longint m_frac = 0;
    int     m_hist [$];
    int     exp_ratio = 0;
    bit     exp_valid = 0;
    bit     started = 0;

    always @(posedge clk) begin
        started = 1;
        if (!rst_n) begin
            foreach (m_acc[k]) m_acc[k] = 0;
            m_int = 31; m_frac = 0;
            m_hist = {0, 0, 0};
            exp_ratio = 0; exp_valid = 0;
        end else begin
            exp_valid = tick_en;
            if (tick_en) begin
                longint feed;
                int cy [3];
                feed = m_frac;
                for (int k = 0; k < 3; k++) begin
                    longint s;
                    s = m_acc[k] + feed;
                    cy[k] = (s >= MODV) ? 1 : 0;
                    m_acc[k] = s % MODV;
                    feed = m_acc[k];
                end
                // m_hist: [0]=previous c2, [1]=previous c3, [2]=c3 two ticks ago
                exp_ratio = m_int + cy[0] + cy[1] - m_hist[0]
                          + cy[2] - 2 * m_hist[1] + m_hist[2];
                m_hist = {cy[1], cy[2], m_hist[1]};
            end
            if (load) begin
                m_int = (int'(int_word) < 31) ? 31 : int'(int_word);
                m_frac = longint'(frac_word);
            end
        end
    end

    // Per-cycle comparison and mean-window accumulation, away from the rising edge
    bit     win = 0;
    longint win_sum = 0;
    int     win_cnt = 0;
    int     win_min = 1 << 20;
    int     win_max = 0;

    always @(negedge clk) begin
        if (started) begin
            // R7 / R6: full cycle-by-cycle sequence against the model
            chk((div_valid == exp_valid) && (!exp_valid || int'(div_ratio) == exp_ratio),
                "R7 sequence", longint'(div_ratio), longint'(exp_ratio));
        end
        if (win && div_valid) begin
            win_sum += longint'(div_ratio);
            win_cnt++;
            if (int'(div_ratio) < win_min) win_min = int'(div_ratio);
            if (int'(div_ratio) > win_max) win_max = int'(div_ratio);
        end
    end

    // Watchdog
    int cycles = 0;
    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic do_load(input int iv, input longint fv, input bit with_tick);
        @(negedge clk);
        int_word = 12'(iv); frac_word = 25'(fv); load = 1'b1; tick_en = with_tick;
        @(negedge clk);
        load = 1'b0; tick_en = 1'b0;
    endtask

    task automatic mean_window(input int iv, input longint fv);
        longint diff;
        do_load(iv, fv, 1'b0);
        win_sum = 0; win_cnt = 0; win_min = 1 << 20; win_max = 0;
        win = 1;
        tick_en = 1'b1;
        repeat (65536) @(negedge clk);
        tick_en = 1'b0;
        repeat (2) @(negedge clk);
        win = 0;
        diff = win_sum * MODV - 64'd65536 * (longint'(iv) * MODV + fv);
        if (diff < 0) diff = -diff;
        chk(win_cnt == 65536, "R8 tick count", win_cnt, 65536);
        chk(diff <= 8 * MODV, "R8 mean", win_sum, 65536 * longint'(iv) + (65536 * fv) / MODV);
        chk(win_min >= iv - 3, "R5 low bound", win_min, iv - 3);
        chk(win_max <= iv + 4, "R5 high bound", win_max, iv + 4);
    endtask

    initial begin
        bit ok;
        int held;
        repeat (3) @(negedge clk);
        // R1: reset values
        chk(div_ratio == 0, "R1 ratio after reset", div_ratio, 0);
        chk(div_valid == 0, "R1 valid after reset", div_valid, 0);
        rst_n = 1'b1;
        tick_en = 1'b1;
        @(negedge clk);
        tick_en = 1'b0;
        chk(div_valid == 1 && div_ratio == 31, "R1 default integer", div_ratio, 31);

        // R4: zero fraction from reset gives exactly the integer word
        do_load(200, 0, 1'b0);
        tick_en = 1'b1;
        ok = 1;
        repeat (20) begin
            @(negedge clk);
            if (div_ratio != 200) ok = 0;
        end
        tick_en = 1'b0;
        chk(ok, "R4 zero fraction", div_ratio, 200);

        // R2: new words without load are ignored
        @(negedge clk);
        int_word = 12'd500; frac_word = 25'd123;
        tick_en = 1'b1;
        repeat (5) @(negedge clk);
        tick_en = 1'b0;
        chk(div_ratio == 200, "R2 no load no effect", div_ratio, 200);

        // R3: integer below the floor is raised to 31
        do_load(5, 0, 1'b0);
        tick_en = 1'b1;
        @(negedge clk);
        tick_en = 1'b0;
        chk(div_ratio == 31, "R3 floor clamp", div_ratio, 31);
        do_load(4095, 0, 1'b0);
        tick_en = 1'b1;
        @(negedge clk);
        tick_en = 1'b0;
        chk(div_ratio == 4095, "R3 top of range", div_ratio, 4095);

        // R9: a load together with a tick uses the old words for that tick
        do_load(1000, 64'd1 << 24, 1'b1);
        chk(div_ratio == 4095, "R9 tick with load uses old words", div_ratio, 4095);

        // R6: sparse ticks; ratio holds and valid drops between them
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); tick_en = 1'b1;
            @(negedge clk); tick_en = 1'b0;
            held = int'(div_ratio);
            @(negedge clk);
        end
        chk(div_valid == 0 && int'(div_ratio) == held, "R6 hold between ticks", div_ratio, held);

        // R8 / R5: long-run mean for the half-integer setting and near full scale
        mean_window(61, 64'd1 << 24);
        mean_window(4095, MODV - 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule